// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritization

This block sits between the receive and transmit datapaths of a 16550-style UART and the register read path. It collects the four interrupt sources: receive line errors, receive data at or above the FIFO trigger level, receive character timeout, and transmit FIFO empty. Each source is masked by its own enable. The block reports the most urgent remaining source as a 4-bit identification value, and it drives an interrupt request line that is high whenever that value names a source.

The line-error, timeout and transmit-empty conditions are held in pending flags. Each flag is cleared only by its own acknowledge event: a line status read, receive FIFO activity, or a transmit holding write. A transmit-empty flag is also cleared by an identification read that returns the transmit-empty code. The receive-data condition is a plain comparison of the FIFO fill level with the trigger level, so it has no pending flag. After reset the transmit-empty source stays blocked for a hold window of one character time less the stop bit, so that software can load the transmit FIFO before the first interrupt.

Top module: `uart_intid`

## Requirements
- R1: Priority, highest first: line error, then receive data, then timeout, then transmit empty. Receive data and timeout share one level, and when both are pending the receive-data code is reported.
- R2: `int_id` only ever takes the codes 4'b0110 (line error), 4'b0100 (receive data), 4'b1100 (timeout), 4'b0010 (transmit empty) and 4'b0001 (none). `irq` equals the inverse of `int_id[0]`.
- R3: Any of `err_overrun`, `err_parity`, `err_framing` or `err_break` sets a sticky line-error flag at the clock edge. `lsr_rd` clears it. If an error flag and `lsr_rd` occur in the same cycle, the flag stays set.
- R4: The receive-data source is active in exactly the cycles where `rx_level >= rx_trig` and `rx_level != 0`. It follows level changes with no storage.
- R5: A `timeout_flag` pulse sets a sticky timeout flag while `rx_level != 0`. `rbr_rd`, `rx_push` or an empty receive FIFO clears it, and clearing wins over setting in the same cycle.
- R6: After the hold window, transmit empty is set when `tx_empty` rises, or when the window ends with `tx_empty` already high. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where `int_id` is 4'b0010. An `iir_rd` while another code is reported leaves it set.
- R7: For the first HOLD = (CHAR_BITS-1)*CLKS_PER_BIT clock edges after reset, transmit empty cannot be set. With `tx_empty` held high it appears after edge HOLD+1.
- R8: A disabled source is removed before prioritization but its pending flag is kept. Enabling it again makes it visible at once.
- R9: During and just after reset `int_id` is 4'b0001 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_line | input | 1 | Enable for line-error source |
| en_rxdata | input | 1 | Enable for receive-data source |
| en_timeout | input | 1 | Enable for timeout source |
| en_tx | input | 1 | Enable for transmit-empty source |
| err_overrun | input | 1 | Overrun detected (pulse) |
| err_parity | input | 1 | Parity error detected (pulse) |
| err_framing | input | 1 | Framing error detected (pulse) |
| err_break | input | 1 | Break detected (pulse) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| timeout_flag | input | 1 | Character timeout reached (pulse) |
| rx_push | input | 1 | Character written into receive FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| int_id | output | 4 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new line error and a line status read. The bench pulses `err_break` together with `lsr_rd` while the line-error code is already reported, and it expects that code to remain afterwards. The second pair is a timeout and receive FIFO activity: a `timeout_flag` pulse arriving with `rbr_rd` must leave the transmit-empty code, not the timeout code. The bench also reads the identification value while receive data is reported, to show that transmit empty survives until the receive level drops.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;

  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_TIMEOUT = 4'b1100,
    ID_TXEMPTY = 4'b0010
  } intid_e;

  // pending-source vector order
  localparam int SRC_LINE    = 0;
  localparam int SRC_RXDATA  = 1;
  localparam int SRC_TIMEOUT = 2;
  localparam int SRC_TXEMPTY = 3;
  localparam int NUM_SRC     = 4;

  function automatic int unsigned hold_cycles(input int unsigned char_bits,
                                              input int unsigned clks_per_bit);
    return (char_bits - 1) * clks_per_bit;
  endfunction

  function automatic logic level_reached(input logic [15:0] level,
                                         input logic [15:0] trig);
    return (level != '0) && (level >= trig);
  endfunction

  function automatic intid_e pick_source(input logic [NUM_SRC-1:0] act);
    if (act[SRC_LINE])         return ID_LINE;
    else if (act[SRC_RXDATA])  return ID_RXDATA;
    else if (act[SRC_TIMEOUT]) return ID_TIMEOUT;
    else if (act[SRC_TXEMPTY]) return ID_TXEMPTY;
    else                       return ID_NONE;
  endfunction

endpackage

// File: rtl/uart_intid_rxsrc.sv
module uart_intid_rxsrc #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       err_vec,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             timeout_flag,
  input  logic             rx_push,
  input  logic             rbr_rd,
  output logic             line_pend,
  output logic             rda_act,
  output logic             cto_pend
);
  import uart_intid_pkg::*;

  logic err_any;
  logic rx_activity;
  logic rx_empty;

  assign err_any     = |err_vec;
  assign rx_activity = rbr_rd | rx_push;
  assign rx_empty    = (rx_level == '0);

  // receive data: level comparison, no storage
  assign rda_act = level_reached(16'(rx_level), 16'(rx_trig));

  // line errors: set beats the read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_pend <= 1'b0;
    else if (err_any) line_pend <= 1'b1;
    else if (lsr_rd)  line_pend <= 1'b0;
  end

  // timeout: FIFO activity or empty FIFO beats a new timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cto_pend <= 1'b0;
    else if (rx_activity || rx_empty)  cto_pend <= 1'b0;
    else if (timeout_flag)             cto_pend <= 1'b1;
  end

endmodule

// File: rtl/uart_intid_txsrc.sv
module uart_intid_txsrc #(
  parameter int unsigned HOLD = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic thr_wr,
  input  logic iir_ack,
  output logic armed,
  output logic thre_pend
);
  localparam int unsigned CW = $clog2(HOLD + 1) + 1;

  logic [CW-1:0] hold_cnt;
  logic          armed_q;
  logic          tx_empty_q;
  logic          thre_set;
  logic          thre_clr;

  assign armed = (hold_cnt == CW'(HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_cnt <= '0;
    else if (!armed) hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      tx_empty_q <= 1'b0;
    end else begin
      armed_q    <= armed;
      tx_empty_q <= tx_empty;
    end
  end

  assign thre_set = armed && tx_empty && (!tx_empty_q || !armed_q);
  assign thre_clr = thr_wr || iir_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thre_pend <= 1'b0;
    else if (thre_clr) thre_pend <= 1'b0;
    else if (thre_set) thre_pend <= 1'b1;
  end

endmodule

// File: rtl/uart_intid_prio.sv
module uart_intid_prio (
  input  logic [3:0] pend,
  input  logic [3:0] enable,
  output logic [3:0] id,
  output logic [3:0] act
);
  import uart_intid_pkg::*;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    assign act[g] = pend[g] & enable[g];
  end

  always_comb id = pick_source(act);

endmodule

// File: rtl/uart_intid.sv
module uart_intid #(
  parameter int          LVL_W        = 5,
  parameter int unsigned CHAR_BITS    = 10,
  parameter int unsigned CLKS_PER_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_line,
  input  logic             en_rxdata,
  input  logic             en_timeout,
  input  logic             en_tx,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             err_break,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             timeout_flag,
  input  logic             rx_push,
  input  logic             tx_empty,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             iir_rd,
  input  logic             thr_wr,
  output logic [3:0]       int_id,
  output logic             irq
);
  import uart_intid_pkg::*;

  localparam int unsigned HOLD = hold_cycles(CHAR_BITS, CLKS_PER_BIT);

  // named internal events
  logic       line_pend;
  logic       rda_act;
  logic       cto_pend;
  logic       thre_pend;
  logic       thre_armed;
  logic       iir_ack;
  logic [3:0] pend_vec;
  logic [3:0] en_vec;
  logic [3:0] act_vec;

  uart_intid_rxsrc #(.LVL_W(LVL_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_vec     ({err_break, err_framing, err_parity, err_overrun}),
    .lsr_rd      (lsr_rd),
    .rx_level    (rx_level),
    .rx_trig     (rx_trig),
    .timeout_flag(timeout_flag),
    .rx_push     (rx_push),
    .rbr_rd      (rbr_rd),
    .line_pend   (line_pend),
    .rda_act     (rda_act),
    .cto_pend    (cto_pend)
  );

  assign iir_ack = iir_rd && (int_id == ID_TXEMPTY);

  uart_intid_txsrc #(.HOLD(HOLD)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_empty (tx_empty),
    .thr_wr   (thr_wr),
    .iir_ack  (iir_ack),
    .armed    (thre_armed),
    .thre_pend(thre_pend)
  );

  always_comb begin
    pend_vec              = '0;
    pend_vec[SRC_LINE]    = line_pend;
    pend_vec[SRC_RXDATA]  = rda_act;
    pend_vec[SRC_TIMEOUT] = cto_pend;
    pend_vec[SRC_TXEMPTY] = thre_pend;
    en_vec                = '0;
    en_vec[SRC_LINE]      = en_line;
    en_vec[SRC_RXDATA]    = en_rxdata;
    en_vec[SRC_TIMEOUT]   = en_timeout;
    en_vec[SRC_TXEMPTY]   = en_tx;
  end

  uart_intid_prio u_prio (
    .pend  (pend_vec),
    .enable(en_vec),
    .id    (int_id),
    .act   (act_vec)
  );

  assign irq = ~int_id[0];

endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       int_id,
  input logic             irq,
  input logic             en_line,
  input logic             en_rxdata,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_trig,
  input logic             err_any,
  input logic             lsr_rd,
  input logic             rbr_rd,
  input logic             rx_push,
  input logic             thr_wr,
  input logic             line_pend,
  input logic             cto_pend,
  input logic             thre_pend,
  input logic             thre_armed
);
  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id == 4'b0001) || (int_id == 4'b0110) || (int_id == 4'b0100) ||
    (int_id == 4'b1100) || (int_id == 4'b0010)); // R2

  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !int_id[0]); // R2

  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_line && line_pend) |-> int_id == 4'b0110); // R1

  AST_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> line_pend); // R3

  AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !err_any) |=> !line_pend); // R3

  AST_RDA_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rxdata && rx_level != 0 && rx_level >= rx_trig && !(en_line && line_pend))
      |-> int_id == 4'b0100); // R4

  AST_CTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd || rx_push) |=> !cto_pend); // R5

  AST_THR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend); // R6

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !thre_armed |-> !thre_pend); // R7

endmodule

bind uart_intid uart_intid_chk #(.LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_id    (int_id),
  .irq       (irq),
  .en_line   (en_line),
  .en_rxdata (en_rxdata),
  .rx_level  (rx_level),
  .rx_trig   (rx_trig),
  .err_any   (err_overrun | err_parity | err_framing | err_break),
  .lsr_rd    (lsr_rd),
  .rbr_rd    (rbr_rd),
  .rx_push   (rx_push),
  .thr_wr    (thr_wr),
  .line_pend (line_pend),
  .cto_pend  (cto_pend),
  .thre_pend (thre_pend),
  .thre_armed(thre_armed)
);

// File: tb/uart_intid_bench.sv
module uart_intid_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 5;
  localparam int HOLD_WIN   = (10 - 1) * 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_line = 1'b1, en_rxdata = 1'b1, en_timeout = 1'b1, en_tx = 1'b1;
  logic             err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] rx_trig = 5'd4;
  logic             timeout_flag = 0, rx_push = 0, tx_empty = 1'b1;
  logic             lsr_rd = 0, rbr_rd = 0, iir_rd = 0, thr_wr = 0;
  logic [3:0]       int_id;
  logic             irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_intid u_uart_intid (
    .clk(clk), .rst_n(rst_n),
    .en_line(en_line), .en_rxdata(en_rxdata), .en_timeout(en_timeout), .en_tx(en_tx),
    .err_overrun(err_overrun), .err_parity(err_parity),
    .err_framing(err_framing), .err_break(err_break),
    .rx_level(rx_level), .rx_trig(rx_trig), .timeout_flag(timeout_flag),
    .rx_push(rx_push), .tx_empty(tx_empty), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .int_id(int_id), .irq(irq)
  );

  task automatic compare(input logic [3:0] exp, input string req);
    n_cmp++;
    if (int_id !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: int_id=%b irq=%b expected int_id=%b irq=%b",
               req, int_id, irq, exp, ~exp[0]);
    end
  endtask

  // monitor: pops one expectation per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), req_q.pop_front());
    end
  end

  // driver step: inputs already set, push expectation, run one edge
  task automatic tick(input logic [3:0] exp, input string req);
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(posedge clk);
    @(negedge clk);
    {err_overrun, err_parity, err_framing, err_break} = '0;
    {timeout_flag, rx_push, lsr_rd, rbr_rd, iir_rd, thr_wr} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(4'b0001, "R9 in reset");
    rst_n = 1'b1;
    // R7: transmit empty held off for HOLD_WIN edges
    for (int i = 0; i < HOLD_WIN; i++) tick(4'b0001, "R7 hold window");
    tick(4'b0010, "R7 after hold");
    // R6 clears and re-sets
    iir_rd = 1; tick(4'b0001, "R6 iir read ack");
    tx_empty = 0; tick(4'b0001, "R6 tx busy");
    tx_empty = 1; tick(4'b0010, "R6 empty rises");
    thr_wr = 1; tx_empty = 0; tick(4'b0001, "R6 thr write");
    tx_empty = 1; tick(4'b0010, "R6 empty again");
    // R4 level comparison
    rx_level = 5'd4; tick(4'b0100, "R4 at trigger");
    rx_level = 5'd3; tick(4'b0010, "R4 below trigger");
    // R3 / R1 line errors over receive data
    rx_level = 5'd4; err_parity = 1; tick(4'b0110, "R1 R3 parity");
    lsr_rd = 1; tick(4'b0100, "R3 lsr read");
    err_overrun = 1; tick(4'b0110, "R3 overrun");
    lsr_rd = 1; err_break = 1; tick(4'b0110, "R3 error with read");
    lsr_rd = 1; tick(4'b0100, "R3 lsr read 2");
    // R6: identification read of another code keeps THRE
    iir_rd = 1; tick(4'b0100, "R6 iir read on rxdata");
    rx_level = 5'd0; tick(4'b0010, "R6 thre survived");
    // R5 timeout
    rx_level = 5'd2; timeout_flag = 1; tick(4'b1100, "R5 timeout set");
    rbr_rd = 1; tick(4'b0010, "R5 rbr read");
    timeout_flag = 1; tick(4'b1100, "R5 timeout set 2");
    rx_push = 1; tick(4'b0010, "R5 rx push");
    timeout_flag = 1; rbr_rd = 1; tick(4'b0010, "R5 clear wins");
    rx_level = 5'd0; timeout_flag = 1; tick(4'b0010, "R5 empty fifo");
    // R1 shared level
    rx_level = 5'd2; timeout_flag = 1; tick(4'b1100, "R1 timeout");
    rx_level = 5'd4; tick(4'b0100, "R1 rxdata over timeout");
    rx_level = 5'd3; tick(4'b1100, "R1 timeout kept");
    rbr_rd = 1; tick(4'b0010, "R5 cleared");
    // R8 masking
    en_tx = 0; tick(4'b0001, "R8 tx masked");
    en_line = 0; err_framing = 1; tick(4'b0001, "R8 line masked");
    en_line = 1; tick(4'b0110, "R8 line latent");
    lsr_rd = 1; tick(4'b0001, "R8 line cleared");
    en_tx = 1; tick(4'b0010, "R8 tx latent");
    en_rxdata = 0; rx_level = 5'd4; tick(4'b0010, "R8 rxdata masked");
    en_rxdata = 1; tick(4'b0100, "R8 rxdata enabled");
    rx_level = 5'd0; tick(4'b0010, "R4 level dropped");
    @(posedge clk); #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule